// File: doc/BRIEF.md
# MMU Domain and Permission Checker

This block rules on a single memory access whose address has already been translated to a section or a small page. It combines three inputs to reach a verdict. The first is the two-bit access type that the domain access register holds for the descriptor's domain. The second is the two-bit access-permission code from the descriptor. The third is the pair of system and ROM protection bits from the control register. The verdict also depends on whether the processor is in user mode and whether the access is a write. The result is a fault class (none, domain or permission) together with an eight-bit fault status word. That word holds the domain number in its upper half and a code in its lower half. The code tells section faults from page faults and domain faults from permission faults.

The decision logic is combinational. One register stage sits behind it. A request strobe captures the inputs. Exactly one clock later the result shows up with a response strobe. Between strobes the outputs keep their last value. The block does not fetch descriptors, compute addresses or sequence aborts. A surrounding MMU gives it the decoded fields and acts on the fault class it returns.

Top module: `mmu_access_checker`

## Requirements
- R1: `rsp_valid` is high in the cycle after each cycle in which `req_valid` was high at the clock edge, and is low after every edge at which `req_valid` was low.
- R2: Domain access type 0 (no access) and type 2 (reserved) yield fault class 1 (domain) for every permission code, mode and direction.
- R3: Domain access type 3 (manager) yields fault class 0 (none) whatever the permission code, mode or direction.
- R4: With domain access type 1 (client), permission code 3 allows everything, code 2 raises class 2 (permission) only for a user-mode write, and code 1 raises class 2 for any user-mode access.
- R5: With client access and permission code 0, the {system, ROM} bits decide. {0,0} faults every access. {0,1} faults writes only. {1,0} allows only supervisor reads. {1,1} faults every access. All of these faults are class 2.
- R6: The low four bits of the status word are 9 for a section domain fault, 11 for a page domain fault, 13 for a section permission fault and 15 for a page permission fault (`is_page` = 1 selects page).
- R7: On a fault, the status bits [7:4] hold the domain number that was presented with the strobe.
- R8: When the class is 0, the status word is zero and `fault_valid` is low. `fault_valid` is high exactly when the class is not 0.
- R9: Reset clears every output to zero. Between strobes, `fault_class`, `fault_valid` and `fault_status` hold their values while the other inputs change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe; the inputs below are captured when it is high |
| dom_access | input | 2 | Domain access type for the descriptor's domain |
| ap_code | input | 2 | Access-permission code from the descriptor |
| sys_prot | input | 1 | System protection bit of the control register |
| rom_prot | input | 1 | ROM protection bit of the control register |
| user_mode | input | 1 | 1 for a user-mode access, 0 for supervisor |
| is_write | input | 1 | 1 for a write, 0 for a read |
| is_page | input | 1 | 1 for a small page, 0 for a section |
| domain_num | input | DOMAIN_W | Domain number of the descriptor |
| rsp_valid | output | 1 | Result strobe, one cycle after `req_valid` |
| fault_class | output | 2 | 0 none, 1 domain, 2 permission |
| fault_valid | output | 1 | High when a fault was found |
| fault_status | output | STATUS_W | Domain number above a four-bit fault code |

## Verification
The properties assume the request fields are stable and meaningful in any cycle where `req_valid` is high. Each property checks the verdict against `$past` of those fields. The properties also assume class encoding 3 is never produced, so they treat `fault_valid` and the class as two views of one fact. The bench drives every field together with the strobe, away from the clock edge. It drops the strobe before it samples, so each observed result belongs to exactly one request. Between strobes it scrambles the fields to show that nothing leaks through without a strobe.

// File: rtl/mmu_chk_pkg.sv
package mmu_chk_pkg;

   typedef enum logic [1:0] {
      FLT_NONE   = 2'd0,
      FLT_DOMAIN = 2'd1,
      FLT_PERM   = 2'd2
   } flt_class_e;

   typedef enum logic [1:0] {
      DA_NOACC   = 2'd0,
      DA_CLIENT  = 2'd1,
      DA_RSVD    = 2'd2,
      DA_MANAGER = 2'd3
   } dom_access_e;

   localparam int unsigned CODE_W = 4;

   localparam logic [CODE_W-1:0] CODE_SEC_DOMAIN  = 4'd9;
   localparam logic [CODE_W-1:0] CODE_PAGE_DOMAIN = 4'd11;
   localparam logic [CODE_W-1:0] CODE_SEC_PERM    = 4'd13;
   localparam logic [CODE_W-1:0] CODE_PAGE_PERM   = 4'd15;

endpackage

// File: rtl/mmu_dom_decode.sv
module mmu_dom_decode
   import mmu_chk_pkg::*;
(
   input  logic [1:0] dom_access,
   output logic       dom_deny,
   output logic       dom_client
);

   dom_access_e acc;
   assign acc = dom_access_e'(dom_access);

   always_comb begin
      dom_deny   = 1'b0;
      dom_client = 1'b0;
      unique case (acc)
         DA_NOACC:   dom_deny   = 1'b1;
         DA_RSVD:    dom_deny   = 1'b1;
         DA_CLIENT:  dom_client = 1'b1;
         DA_MANAGER: ;
         default:    dom_deny   = 1'b1;
      endcase
   end

endmodule

// File: rtl/mmu_ap_decode.sv
module mmu_ap_decode (
   input  logic [1:0] ap_code,
   input  logic       sys_prot,
   input  logic       rom_prot,
   input  logic       user_mode,
   input  logic       is_write,
   output logic       perm_deny
);

   logic ap0_deny;

   always_comb begin
      unique case ({sys_prot, rom_prot})
         2'b00:   ap0_deny = 1'b1;
         2'b01:   ap0_deny = is_write;
         2'b10:   ap0_deny = user_mode | is_write;
         default: ap0_deny = 1'b1;
      endcase
   end

   always_comb begin
      unique case (ap_code)
         2'd0:    perm_deny = ap0_deny;
         2'd1:    perm_deny = user_mode;
         2'd2:    perm_deny = user_mode & is_write;
         default: perm_deny = 1'b0;
      endcase
   end

endmodule

// File: rtl/mmu_status_enc.sv
module mmu_status_enc
   import mmu_chk_pkg::*;
#(
   parameter int unsigned DOMAIN_W = 4,
   parameter int unsigned STATUS_W = 8
) (
   input  logic [1:0]          fclass,
   input  logic                is_page,
   input  logic [DOMAIN_W-1:0] domain_num,
   output logic [STATUS_W-1:0] status
);

   localparam int unsigned USED_W = CODE_W + DOMAIN_W;
   localparam int unsigned PAD_W  = (STATUS_W > USED_W) ? STATUS_W - USED_W : 0;

   logic [CODE_W-1:0] code;
   logic [USED_W-1:0] packed_word;
   logic              faulted;

   always_comb begin
      unique case (flt_class_e'(fclass))
         FLT_DOMAIN: code = is_page ? CODE_PAGE_DOMAIN : CODE_SEC_DOMAIN;
         FLT_PERM:   code = is_page ? CODE_PAGE_PERM   : CODE_SEC_PERM;
         default:    code = '0;
      endcase
   end

   assign faulted     = (fclass != FLT_NONE);
   assign packed_word = faulted ? {domain_num, code} : '0;

   generate
      if (STATUS_W < USED_W) begin : g_bad_width
         $error("mmu_status_enc: STATUS_W too narrow for domain and code");
      end
      if (PAD_W > 0) begin : g_pad
         assign status = {{PAD_W{1'b0}}, packed_word};
      end else begin : g_exact
         assign status = packed_word[STATUS_W-1:0];
      end
   endgenerate

endmodule

// File: rtl/mmu_access_checker.sv
module mmu_access_checker
   import mmu_chk_pkg::*;
#(
   parameter int unsigned DOMAIN_W = 4,
   parameter int unsigned STATUS_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [1:0]          dom_access,
   input  logic [1:0]          ap_code,
   input  logic                sys_prot,
   input  logic                rom_prot,
   input  logic                user_mode,
   input  logic                is_write,
   input  logic                is_page,
   input  logic [DOMAIN_W-1:0] domain_num,
   output logic                rsp_valid,
   output logic [1:0]          fault_class,
   output logic                fault_valid,
   output logic [STATUS_W-1:0] fault_status
);

   generate
      if (DOMAIN_W < 1) begin : g_bad_dom
         $error("mmu_access_checker: DOMAIN_W must be at least 1");
      end
   endgenerate

   logic                dom_deny;
   logic                dom_client;
   logic                perm_deny;
   logic [1:0]          cls_d;
   logic [STATUS_W-1:0] status_d;

   mmu_dom_decode u_dom (
      .dom_access (dom_access),
      .dom_deny   (dom_deny),
      .dom_client (dom_client)
   );

   mmu_ap_decode u_ap (
      .ap_code   (ap_code),
      .sys_prot  (sys_prot),
      .rom_prot  (rom_prot),
      .user_mode (user_mode),
      .is_write  (is_write),
      .perm_deny (perm_deny)
   );

   always_comb begin
      if (dom_deny)                     cls_d = FLT_DOMAIN;
      else if (dom_client && perm_deny) cls_d = FLT_PERM;
      else                              cls_d = FLT_NONE;
   end

   mmu_status_enc #(
      .DOMAIN_W (DOMAIN_W),
      .STATUS_W (STATUS_W)
   ) u_enc (
      .fclass     (cls_d),
      .is_page    (is_page),
      .domain_num (domain_num),
      .status     (status_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         fault_class  <= FLT_NONE;
         fault_valid  <= 1'b0;
         fault_status <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            fault_class  <= cls_d;
            fault_valid  <= dom_deny | (dom_client & perm_deny);
            fault_status <= status_d;
         end
      end
   end

endmodule

// File: rtl/mmu_access_checker_sva.sv
module mmu_access_checker_sva #(
   parameter int unsigned DOMAIN_W = 4,
   parameter int unsigned STATUS_W = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid,
   input logic [1:0]          dom_access,
   input logic [1:0]          ap_code,
   input logic                sys_prot,
   input logic                rom_prot,
   input logic                user_mode,
   input logic                is_write,
   input logic                is_page,
   input logic [DOMAIN_W-1:0] domain_num,
   input logic                rsp_valid,
   input logic [1:0]          fault_class,
   input logic                fault_valid,
   input logic [STATUS_W-1:0] fault_status
);

   AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid); // R1

   AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid); // R1

   AST_NOACC_DOMAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (dom_access == 2'd0 || dom_access == 2'd2)) |=> (fault_class == 2'd1)); // R2

   AST_MANAGER_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && dom_access == 2'd3) |=> (fault_class == 2'd0 && !fault_valid)); // R3

   AST_CLIENT_FULL_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && dom_access == 2'd1 && ap_code == 2'd3) |=> (fault_class == 2'd0)); // R4

   AST_DOMAIN_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && dom_access == 2'd0) |=> (fault_status[7:4] == $past(domain_num[3:0]))); // R7

   AST_CLEAN_ZERO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_valid |-> (fault_status == '0)); // R8

   AST_VALID_MATCHES_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid == (fault_class != 2'd0)); // R8

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> ($stable(fault_status) && $stable(fault_class))); // R9

endmodule

bind mmu_access_checker mmu_access_checker_sva #(
   .DOMAIN_W (DOMAIN_W),
   .STATUS_W (STATUS_W)
) u_sva (.*);

// File: tb/mmu_access_checker_tb_top.sv
module mmu_access_checker_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [1:0] dom_access = '0;
   logic [1:0] ap_code = '0;
   logic       sys_prot = 1'b0;
   logic       rom_prot = 1'b0;
   logic       user_mode = 1'b0;
   logic       is_write = 1'b0;
   logic       is_page = 1'b0;
   logic [3:0] domain_num = '0;
   logic       rsp_valid;
   logic [1:0] fault_class;
   logic       fault_valid;
   logic [7:0] fault_status;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #5 clk = ~clk;

   mmu_access_checker dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .dom_access   (dom_access),
      .ap_code      (ap_code),
      .sys_prot     (sys_prot),
      .rom_prot     (rom_prot),
      .user_mode    (user_mode),
      .is_write     (is_write),
      .is_page      (is_page),
      .domain_num   (domain_num),
      .rsp_valid    (rsp_valid),
      .fault_class  (fault_class),
      .fault_valid  (fault_valid),
      .fault_status (fault_status)
   );

   // {dom, ap, s, r, user, write, page, domain, class, status}
   localparam int NV = 18;
   localparam logic [22:0] VECS [NV] = '{
      {2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h5, 2'd1, 8'h59},
      {2'd2, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'hA, 2'd1, 8'hAB},
      {2'd3, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'h3, 2'd0, 8'h00},
      {2'd1, 2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'h7, 2'd0, 8'h00},
      {2'd1, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'h2, 2'd2, 8'h2D},
      {2'd1, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'h2, 2'd0, 8'h00},
      {2'd1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'h4, 2'd0, 8'h00},
      {2'd1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'h6, 2'd2, 8'h6F},
      {2'd1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'h6, 2'd0, 8'h00},
      {2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h1, 2'd2, 8'h1D},
      {2'd1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'h1, 2'd0, 8'h00},
      {2'd1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'h8, 2'd2, 8'h8F},
      {2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'h9, 2'd0, 8'h00},
      {2'd1, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'h9, 2'd2, 8'h9F},
      {2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'hC, 2'd2, 8'hCD},
      {2'd1, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'hE, 2'd2, 8'hEF},
      {2'd0, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 2'd1, 8'hFB},
      {2'd3, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'h0, 2'd0, 8'h00}
   };

   function automatic logic [1:0] model_class(input logic [1:0] d, input logic [1:0] a,
                                              input logic s, input logic r,
                                              input logic u, input logic w);
      logic deny;
      if (d == 2'd0 || d == 2'd2) return 2'd1;
      if (d == 2'd3) return 2'd0;
      case (a)
         2'd3: deny = 1'b0;
         2'd2: deny = u & w;
         2'd1: deny = u;
         default: begin
            if (!s && r)      deny = w;
            else if (s && !r) deny = u | w;
            else              deny = 1'b1;
         end
      endcase
      return deny ? 2'd2 : 2'd0;
   endfunction

   function automatic logic [7:0] model_status(input logic [1:0] c, input logic pg,
                                               input logic [3:0] dn);
      if (c == 2'd1) return {dn, pg ? 4'd11 : 4'd9};
      if (c == 2'd2) return {dn, pg ? 4'd15 : 4'd13};
      return 8'h00;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [1:0] d, input logic [1:0] a, input logic s,
                        input logic r, input logic u, input logic w,
                        input logic pg, input logic [3:0] dn);
      @(negedge clk);
      dom_access = d; ap_code = a; sys_prot = s; rom_prot = r;
      user_mode = u; is_write = w; is_page = pg; domain_num = dn;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic check_result(input string req, input logic [1:0] ec, input logic [7:0] es);
      check({req, " rsp_valid"}, 32'(rsp_valid), 32'd1);
      check({req, " class"}, 32'(fault_class), 32'(ec));
      check({req, " status"}, 32'(fault_status), 32'(es));
      check({"R8 fault_valid"}, 32'(fault_valid), 32'(ec != 2'd0));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      // R9 reset state
      repeat (2) @(negedge clk);
      check("R9 reset rsp_valid", 32'(rsp_valid), 32'd0);
      check("R9 reset class", 32'(fault_class), 32'd0);
      check("R9 reset status", 32'(fault_status), 32'd0);
      check("R9 reset fault_valid", 32'(fault_valid), 32'd0);
      rst_n = 1'b1;

      // table walk: R2 R3 R4 R5 R6 R7 R8
      for (int i = 0; i < NV; i++) begin
         logic [22:0] v;
         v = VECS[i];
         issue(v[22:21], v[20:19], v[18], v[17], v[16], v[15], v[14], v[13:10]);
         check_result($sformatf("R2-table vec %0d (R4 R5 R6 R7)", i), v[9:8], v[7:0]);
      end

      // exhaustive sweep against requirement model: R2 R3 R4 R5 R6
      for (int k = 0; k < 512; k++) begin
         logic [8:0] b;
         logic [1:0] ec;
         logic [3:0] dn;
         b  = 9'(k);
         dn = 4'(k * 7);
         ec = model_class(b[8:7], b[6:5], b[4], b[3], b[2], b[1]);
         issue(b[8:7], b[6:5], b[4], b[3], b[2], b[1], b[0], dn);
         check_result("R5 sweep", ec, model_status(ec, b[0], dn));
      end

      // R1: strobe gap produces no response
      @(negedge clk);
      check("R1 idle rsp_valid", 32'(rsp_valid), 32'd0);

      // R9: hold between strobes while inputs change
      issue(2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'h3);
      check("R9 setup status", 32'(fault_status), 32'h3F);
      dom_access = 2'd3; ap_code = 2'd3; domain_num = 4'hC; is_page = 1'b0;
      repeat (3) @(negedge clk);
      check("R9 hold status", 32'(fault_status), 32'h3F);
      check("R9 hold class", 32'(fault_class), 32'd2);
      check("R1 hold rsp_valid", 32'(rsp_valid), 32'd0);

      // back-to-back strobes: R1
      @(negedge clk);
      dom_access = 2'd2; domain_num = 4'h1; is_page = 1'b0; req_valid = 1'b1;
      @(negedge clk);
      check("R1 b2b first", 32'(fault_status), 32'h19);
      dom_access = 2'd3;
      @(negedge clk);
      req_valid = 1'b0;
      check("R1 b2b second rsp", 32'(rsp_valid), 32'd1);
      check("R3 b2b second status", 32'(fault_status), 32'h00);

      // R9 mid-run reset clears a fault
      issue(2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'hF);
      check("R7 max domain", 32'(fault_status), 32'hFB);
      rst_n = 1'b0;
      #1;
      check("R9 async reset status", 32'(fault_status), 32'd0);
      check("R9 async reset valid", 32'(fault_valid), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule